// File: doc/BRIEF.md
# Cascaded 5-to-32 Address Decoder

This block turns a 5-bit address into a 32-bit one-hot select vector. It is built from five copies of one enabled 3-to-8 leaf decoder, not from a flat 32-way decode. A selector leaf decodes the two upper address bits. Its active-low outputs gate the enables of four output leaves. All four output leaves share the three lower address bits, so only the output leaf whose enable is active drives a select line.

A top-level enable feeds only the selector leaf. Dropping it turns off the selector and, through it, every output leaf. A parameter chooses whether the 32 outputs are active-high or active-low. The address travels through two leaf stages in series, so a change to the upper bits passes through the selector before it reaches any output.

Top module: `dec5to32_cascade`

## Requirements
- R1: With `en_i` = 1, exactly one output is at its active level and every other output is at its inactive level.
- R2: The active output index equals 8 × `addr_i[4:3]` + `addr_i[2:0]`. For example, address 5'b10000 selects output 16 and 5'b10111 selects output 23.
- R3: With `en_i` = 0, every output is at its inactive level for all 32 addresses.
- R4: With `ACT_LOW` = 0 the active level is 1 and the inactive level is 0. With `ACT_LOW` = 1 the active level is 0 and the inactive level is 1.
- R5: With `en_i` = 1 the selector stage enables exactly one output leaf, namely leaf `addr_i[4:3]`, which owns outputs 8k to 8k+7. With `en_i` = 0 it enables none.
- R6: An output leaf that is not enabled keeps all of its outputs inactive, including output 8j + `addr_i[2:0]` that its own address inputs point at.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 5 | Address; bits 4:3 pick the output leaf, bits 2:0 pick the line within it |
| en_i | input | 1 | Top-level enable, active high, gates the selector stage |
| dec_o | output | 32 | One-hot select vector, polarity set by `ACT_LOW` |

## Verification
The hardest case to reach is R6. Three of the four output leaves see a lower address that matches one of their lines, and each must still stay silent only because the selector withholds its enable. The sweep covers this case directly. For every address with the enable on, the bench looks at the same line position in each of the other three blocks of eight. It also runs the full sweep with the enable off and on, against both polarity builds, so that gating the selector is the only thing that could silence the whole tree.

// File: rtl/dec_cascade_pkg.sv
package dec_cascade_pkg;
  function automatic int unsigned fanout(input int unsigned w);
    return 1 << w;
  endfunction
endpackage

// File: rtl/dec_leaf.sv
// Enabled leaf decoder: one active-high gate, two active-low gates, active-low outputs.
module dec_leaf #(
  parameter int unsigned W     = 3,
  parameter int unsigned N_OUT = 8
) (
  input  logic [W-1:0]     a_i,
  input  logic             g_hi_i,
  input  logic             g_lo_a_ni,
  input  logic             g_lo_b_ni,
  output logic [N_OUT-1:0] y_no
);
  logic gate_on;
  assign gate_on = g_hi_i & ~g_lo_a_ni & ~g_lo_b_ni;

  for (genvar j = 0; j < N_OUT; j++) begin : g_line
    assign y_no[j] = ~(gate_on & (a_i == W'(j)));
  end
endmodule

// File: rtl/dec_polarity.sv
module dec_polarity #(
  parameter int unsigned N       = 32,
  parameter bit          ACT_LOW = 1'b0
) (
  input  logic [N-1:0] sel_ni,
  output logic [N-1:0] sel_o
);
  if (ACT_LOW) begin : g_low
    assign sel_o = sel_ni;
  end else begin : g_high
    assign sel_o = ~sel_ni;
  end
endmodule

// File: rtl/dec5to32_cascade.sv
module dec5to32_cascade
  import dec_cascade_pkg::*;
#(
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned LEAF_W  = 3,
  parameter bit          ACT_LOW = 1'b0,
  localparam int unsigned ADDR_W = SEL_W + LEAF_W,
  localparam int unsigned NSTG   = fanout(SEL_W),
  localparam int unsigned NLEAF  = fanout(LEAF_W),
  localparam int unsigned NOUT   = NSTG * NLEAF
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  output logic [NOUT-1:0]   dec_o
);
  logic [NSTG-1:0]   stage_en_n;
  logic [NOUT-1:0]   raw_n;
  logic [LEAF_W-1:0] sel_addr;

  // selector leaf sees upper bits zero-extended to leaf width
  assign sel_addr = LEAF_W'(addr_i[ADDR_W-1:LEAF_W]);

  dec_leaf #(.W(LEAF_W), .N_OUT(NSTG)) i_sel (
    .a_i       (sel_addr),
    .g_hi_i    (en_i),
    .g_lo_a_ni (1'b0),
    .g_lo_b_ni (1'b0),
    .y_no      (stage_en_n)
  );

  for (genvar k = 0; k < NSTG; k++) begin : g_stage
    dec_leaf #(.W(LEAF_W), .N_OUT(NLEAF)) i_out (
      .a_i       (addr_i[LEAF_W-1:0]),
      .g_hi_i    (1'b1),
      .g_lo_a_ni (stage_en_n[k]),
      .g_lo_b_ni (1'b0),
      .y_no      (raw_n[k*NLEAF +: NLEAF])
    );
  end

  dec_polarity #(.N(NOUT), .ACT_LOW(ACT_LOW)) i_pol (
    .sel_ni (raw_n),
    .sel_o  (dec_o)
  );
endmodule

// File: rtl/dec5to32_cascade_chk.sv
module dec5to32_cascade_chk #(
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned LEAF_W  = 3,
  parameter bit          ACT_LOW = 1'b0,
  localparam int unsigned ADDR_W = SEL_W + LEAF_W,
  localparam int unsigned NSTG   = 1 << SEL_W,
  localparam int unsigned NOUT   = NSTG << LEAF_W
) (
  input logic [ADDR_W-1:0] addr_i,
  input logic              en_i,
  input logic [NOUT-1:0]   dec_o,
  input logic [NSTG-1:0]   stage_en_n
);
  logic [NOUT-1:0] act;
  assign act = ACT_LOW ? ~dec_o : dec_o;

  always_comb begin
    if (!$isunknown({addr_i, en_i, dec_o, stage_en_n})) begin
      // R1
      onehot_chk: assert (!en_i || $countones(act) == 1);
      // R2
      index_chk: assert (!en_i || act[addr_i]);
      // R3
      idle_chk: assert (en_i || act == '0);
      // R5
      stage_sel_chk: assert (en_i ? ($countones(~stage_en_n) == 1 && !stage_en_n[addr_i[ADDR_W-1:LEAF_W]])
                                  : (stage_en_n == '1));
    end
  end
endmodule

bind dec5to32_cascade dec5to32_cascade_chk #(
  .SEL_W(SEL_W), .LEAF_W(LEAF_W), .ACT_LOW(ACT_LOW)
) i_chk (
  .addr_i     (addr_i),
  .en_i       (en_i),
  .dec_o      (dec_o),
  .stage_en_n (stage_en_n)
);

// File: tb/test_dec5to32_cascade.sv
module test_dec5to32_cascade;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] addr = '0;
  logic       en = 1'b0;
  logic [31:0] out_hi, out_lo;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  dec5to32_cascade #(.ACT_LOW(1'b0)) i_dec5to32_cascade (
    .addr_i(addr), .en_i(en), .dec_o(out_hi));
  dec5to32_cascade #(.ACT_LOW(1'b1)) i_dec5to32_cascade_al (
    .addr_i(addr), .en_i(en), .dec_o(out_lo));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s addr=%0d en=%0b act=%h exp=%h", req, addr, en, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] a, input logic e);
    @(posedge clk);
    addr = a;
    en = e;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: enable low
    chk("R3", out_hi, 32'h0);
    chk("R4", out_lo, 32'hffff_ffff);
    rst_n = 1'b1;

    for (int e = 0; e < 2; e++) begin
      for (int a = 0; a < 32; a++) begin
        logic [31:0] exp;
        apply(5'(a), e[0]);
        exp = e[0] ? (32'h1 << a) : 32'h0;
        chk(e[0] ? "R1" : "R3", out_hi, exp);
        chk("R4", out_lo, ~exp);
        if (e[0]) begin
          // R5: block of addr[4:3] holds the active line, others silent
          for (int k = 0; k < 4; k++)
            chk("R5", {24'h0, out_hi[k*8 +: 8]},
                (k == a/8) ? {24'h0, 8'h1 << (a%8)} : 32'h0);
          // R6: same line position in non-selected blocks stays inactive
          for (int j = 0; j < 4; j++)
            if (j != a/8) begin
              chk("R6", {31'h0, out_hi[j*8 + a%8]}, 32'h0);
              chk("R6", {31'h0, out_lo[j*8 + a%8]}, 32'h1);
            end
        end
      end
    end

    // R2 spot checks on index arithmetic
    apply(5'b10000, 1'b1);
    chk("R2", out_hi, 32'h1 << 16);
    apply(5'b10111, 1'b1);
    chk("R2", out_hi, 32'h1 << 23);
    apply(5'b01101, 1'b1);
    chk("R2", out_lo, ~(32'h1 << 13));
    apply(5'b11111, 1'b0);
    chk("R3", out_lo, 32'hffff_ffff);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule